// File: doc/BRIEF.md
# PWM Sequence Sample Player

This block plays one sequence of 16-bit duty samples for a four-channel PWM generator. A start pulse snapshots the sequence configuration and reads sample half-words from a half-word-addressed sample memory. The player groups the half-words into sample sets and hands each set to the compare registers of the four channels. It reads ahead by one set: the next set waits in a shadow buffer and reaches the outputs only on a period-end pulse from the external wave counter. A duty change therefore always lands on a period boundary.

A load mode chooses how the half-words of a set are spread over the channels. One of the modes also supplies the counter top of the wave counter. An advance mode chooses how the player moves through the sequence. In one mode it moves after a programmable number of PWM periods. In the other it moves only after an explicit step pulse. Once the last set has had its hold time, the player counts a programmable end delay in PWM periods. It then reports that it is done and drops its running flag. The wave counter, the arbitration of memory access and any looping across several sequences live outside this block.

Top module: `pwm_seq_player`

## Requirements
- R1: Load mode 0 uses one half-word per set, and that half-word drives all four channels.
- R2: Load mode 1 uses two half-words per set. The first drives channels 0 and 1, and the second drives channels 2 and 3.
- R3: Load mode 2 uses four consecutive half-words per set, which drive channels 0, 1, 2 and 3 in that order.
- R4: Load mode 3 uses four half-words per set. The first three drive channels 0 to 2, and channel 3 gets compare 0 with polarity 0. Bits 14:0 of the fourth half-word appear on `top_val` with `top_from_mem` high. In every other mode a commit sets `top_val` to 0 and `top_from_mem` low.
- R5: In each sample, bit 15 is the channel polarity (`cmp_pol`) and bits 14:0 are the compare value. Channel c occupies `cmp_val[15c+14:15c]`.
- R6: With `step_mode` = 0, set n takes effect at period-end number n×(refresh+1), counted from the commit of the first set. A refresh value of 0 moves to a new set on every period end.
- R7: With `step_mode` = 1, the sequence advances only at the first period end that follows a `next_step` pulse. A `next_step` pulse while the block is not running has no effect and starts nothing.
- R8: A start with a nonzero count from idle commits set 0 without waiting for a period end. In that cycle `running` rises and `seq_started` pulses. A start while running commits the new set 0 at the next period end, and `seq_started` pulses then.
- R9: A start with `seq_cnt` = 0 is ignored: no memory read, no pulse, and no change to any output.
- R10: A sequence of `seq_cnt` half-words has ceil(`seq_cnt`/k) sets, where k is 1, 2 or 4 for the load mode. A partial last set still reads a full group. `seq_end` pulses once, when the last set is committed.
- R11: The last set holds for refresh+1 periods, or in step mode until a step and then a period end. The player then waits `end_delay` more period ends. After that, `seq_done` pulses and `running` falls in the same cycle. With `end_delay` = 0 this happens at the end of the hold.
- R12: The compare outputs change only in the cycle after a commit. While running, a commit happens only on a period end. Reset clears all outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start pulse for the configured sequence |
| next_step | input | 1 | Step request pulse (step mode) |
| period_end | input | 1 | Period-end pulse from the wave counter |
| seq_ptr | input | AW | Half-word address of the first sample |
| seq_cnt | input | CW | Number of half-words in the sequence |
| refresh_per | input | RW | Extra periods that each set is held |
| end_delay | input | RW | Periods waited after the last set |
| load_mode | input | 2 | Spread of half-words over channels (0..3) |
| step_mode | input | 1 | 0: advance by period count, 1: advance by step pulse |
| mem_rd | output | 1 | Memory read strobe |
| mem_addr | output | AW | Memory half-word address |
| mem_rdata | input | DW | Read data, valid one cycle after `mem_rd` |
| cmp_val | output | 4*(DW-1) | Compare values of channels 0..3 |
| cmp_pol | output | 4 | Polarity bits of channels 0..3 |
| top_val | output | DW-1 | Counter top taken from memory |
| top_from_mem | output | 1 | `top_val` is valid (load mode 3) |
| running | output | 1 | Generation active |
| seq_started | output | 1 | Pulse: first set of the sequence committed |
| seq_end | output | 1 | Pulse: last set of the sequence committed |
| seq_done | output | 1 | Pulse: end delay elapsed, playback finished |

## Verification
The hardest case to reach from the ports is a restart that arrives while the player is already running. In that case the freshly fetched first set must wait in the shadow buffer and must not disturb the outputs that are still playing. The bench finishes part of one sequence and then issues a new start with a different pointer. It samples the outputs during several idle cycles before it sends the next period end, and only after that period end does it expect the new set. Random runs mix all four load modes, both advance modes, partial last sets and zero or nonzero delays. They are compared period by period against a model that computes the addresses and sample values from scratch.

// File: rtl/pwm_seq_pkg.sv
package pwm_seq_pkg;

  localparam int NCH   = 4;
  localparam int NSLOT = 4;

  typedef enum logic [1:0] {
    LD_COMMON  = 2'd0,
    LD_GROUPED = 2'd1,
    LD_INDIV   = 2'd2,
    LD_WAVE    = 2'd3
  } load_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PLAY  = 2'd1,
    ST_TAIL  = 2'd2,
    ST_DELAY = 2'd3
  } play_state_e;

  // half-words consumed per sample set
  function automatic logic [2:0] hw_per_set(input logic [1:0] mode);
    case (mode)
      LD_COMMON:  return 3'd1;
      LD_GROUPED: return 3'd2;
      default:    return 3'd4;
    endcase
  endfunction

  // shadow slot that feeds a given channel
  function automatic int src_slot(input logic [1:0] mode, input int ch);
    case (mode)
      LD_COMMON:  return 0;
      LD_GROUPED: return ch / 2;
      default:    return ch;
    endcase
  endfunction

  // channel 3 carries no sample in waveform mode
  function automatic logic chan_live(input logic [1:0] mode, input int ch);
    return !((mode == LD_WAVE) && (ch == NCH - 1));
  endfunction

endpackage

// File: rtl/pwm_seq_fetch.sv
module pwm_seq_fetch
  import pwm_seq_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                go,
  input  logic [AW-1:0]       base,
  input  logic [2:0]          nwords,
  output logic                mem_rd,
  output logic [AW-1:0]       mem_addr,
  input  logic [DW-1:0]       mem_rdata,
  output logic [NSLOT*DW-1:0] raw_flat,
  output logic                ready
);

  logic          busy_q;
  logic [2:0]    iss_q;
  logic [2:0]    nw_q;
  logic [AW-1:0] base_q;
  logic          rv_q;
  logic          rlast_q;
  logic [1:0]    rslot_q;
  logic          rdy_q;
  logic [DW-1:0] slot_q [NSLOT];

  assign mem_rd   = busy_q;
  assign mem_addr = base_q + AW'(iss_q);
  assign ready    = rdy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      iss_q   <= '0;
      nw_q    <= '0;
      base_q  <= '0;
      rv_q    <= 1'b0;
      rlast_q <= 1'b0;
      rslot_q <= '0;
      rdy_q   <= 1'b0;
      for (int i = 0; i < NSLOT; i++) slot_q[i] <= '0;
    end else begin
      rv_q    <= mem_rd && !go;
      rslot_q <= iss_q[1:0];
      rlast_q <= (iss_q == nw_q - 3'd1);
      rdy_q   <= rv_q && rlast_q && !go;
      if (go) begin
        busy_q <= 1'b1;
        iss_q  <= '0;
        nw_q   <= nwords;
        base_q <= base;
      end else if (busy_q) begin
        iss_q <= iss_q + 3'd1;
        if (iss_q == nw_q - 3'd1) busy_q <= 1'b0;
      end
      if (rv_q) slot_q[rslot_q] <= mem_rdata;
    end
  end

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    assign raw_flat[s*DW +: DW] = slot_q[s];
  end

endmodule

// File: rtl/pwm_seq_percnt.sv
module pwm_seq_percnt #(
  parameter int W = 23
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         tick,
  input  logic [W-1:0] limit,
  output logic         hit
);

  logic [W-1:0] cnt_q;

  assign hit = tick && (cnt_q == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (clr)  cnt_q <= '0;
    else if (tick) cnt_q <= hit ? '0 : cnt_q + 1'b1;
  end

endmodule

// File: rtl/pwm_seq_cmpbank.sv
module pwm_seq_cmpbank
  import pwm_seq_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  commit,
  input  logic [1:0]            mode,
  input  logic [NSLOT*DW-1:0]   raw_flat,
  output logic [NCH*(DW-1)-1:0] cmp_val,
  output logic [NCH-1:0]        cmp_pol,
  output logic [DW-2:0]         top_val,
  output logic                  top_from_mem
);

  localparam int CVW = DW - 1;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [DW-1:0]  pick;
    logic [CVW-1:0] val_q;
    logic           pol_q;

    always_comb begin
      pick = raw_flat[src_slot(mode, c)*DW +: DW];
      if (!chan_live(mode, c)) pick = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        val_q <= '0;
        pol_q <= 1'b0;
      end else if (commit) begin
        val_q <= pick[CVW-1:0];
        pol_q <= pick[DW-1];
      end
    end

    assign cmp_val[c*CVW +: CVW] = val_q;
    assign cmp_pol[c]            = pol_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      top_val      <= '0;
      top_from_mem <= 1'b0;
    end else if (commit) begin
      if (mode == LD_WAVE) begin
        top_val      <= raw_flat[(NSLOT-1)*DW +: CVW];
        top_from_mem <= 1'b1;
      end else begin
        top_val      <= '0;
        top_from_mem <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/pwm_seq_player.sv
module pwm_seq_player
  import pwm_seq_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int CW = 14,
  parameter int RW = 23
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic                  next_step,
  input  logic                  period_end,
  input  logic [AW-1:0]         seq_ptr,
  input  logic [CW-1:0]         seq_cnt,
  input  logic [RW-1:0]         refresh_per,
  input  logic [RW-1:0]         end_delay,
  input  logic [1:0]            load_mode,
  input  logic                  step_mode,
  output logic                  mem_rd,
  output logic [AW-1:0]         mem_addr,
  input  logic [DW-1:0]         mem_rdata,
  output logic [NCH*(DW-1)-1:0] cmp_val,
  output logic [NCH-1:0]        cmp_pol,
  output logic [DW-2:0]         top_val,
  output logic                  top_from_mem,
  output logic                  running,
  output logic                  seq_started,
  output logic                  seq_end,
  output logic                  seq_done
);

  localparam int OW = CW + 3;

  play_state_e st_q;
  logic          run_q, first_q, shadow_rdy_q, shadow_last_q, pend_q;
  logic [AW-1:0] ptr_q;
  logic [CW-1:0] cnt_q;
  logic [RW-1:0] refr_q, dly_q;
  logic [1:0]    mode_q;
  logic          step_q;
  logic [2:0]    k_q;
  logic [OW-1:0] off_q;
  logic          started_q, end_q, done_q;

  // named internal events
  logic              start_ok, fetch_go, fetch_rdy, commit_evt, adv_evt;
  logic              per_hit, per_clr, per_tick, tail_expire, finish_evt;
  logic [RW-1:0]     per_limit;
  logic [AW-1:0]     fetch_base;
  logic [2:0]        fetch_k;
  logic              last_next;
  logic [NSLOT*DW-1:0] raw_flat;

  assign start_ok = start && (seq_cnt != '0);
  assign adv_evt  = run_q && period_end && (step_q ? pend_q : per_hit);

  always_comb begin
    commit_evt = 1'b0;
    if (!start_ok && st_q == ST_PLAY && shadow_rdy_q)
      commit_evt = first_q ? (!run_q || period_end) : adv_evt;
  end

  assign tail_expire = !start_ok && (st_q == ST_TAIL) && adv_evt;
  assign finish_evt  = !start_ok &&
                       ((tail_expire && dly_q == '0) ||
                        (st_q == ST_DELAY && period_end && per_hit));

  assign fetch_go   = start_ok || (commit_evt && !shadow_last_q);
  assign fetch_k    = start_ok ? hw_per_set(load_mode) : k_q;
  assign fetch_base = start_ok ? seq_ptr : ptr_q + AW'(off_q + OW'(k_q));
  assign last_next  = start_ok ? (OW'(fetch_k) >= OW'(seq_cnt))
                               : ((off_q + OW'({k_q, 1'b0})) >= OW'(cnt_q));

  assign per_tick  = run_q && period_end;
  assign per_clr   = start_ok || commit_evt || tail_expire;
  assign per_limit = (st_q == ST_DELAY) ? dly_q - 1'b1 : refr_q;

  pwm_seq_fetch #(.AW(AW), .DW(DW)) u_fetch (
    .clk      (clk),
    .rst_n    (rst_n),
    .go       (fetch_go),
    .base     (fetch_base),
    .nwords   (fetch_k),
    .mem_rd   (mem_rd),
    .mem_addr (mem_addr),
    .mem_rdata(mem_rdata),
    .raw_flat (raw_flat),
    .ready    (fetch_rdy)
  );

  pwm_seq_percnt #(.W(RW)) u_percnt (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (per_clr),
    .tick (per_tick),
    .limit(per_limit),
    .hit  (per_hit)
  );

  pwm_seq_cmpbank #(.DW(DW)) u_bank (
    .clk         (clk),
    .rst_n       (rst_n),
    .commit      (commit_evt),
    .mode        (mode_q),
    .raw_flat    (raw_flat),
    .cmp_val     (cmp_val),
    .cmp_pol     (cmp_pol),
    .top_val     (top_val),
    .top_from_mem(top_from_mem)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q          <= ST_IDLE;
      run_q         <= 1'b0;
      first_q       <= 1'b0;
      shadow_rdy_q  <= 1'b0;
      shadow_last_q <= 1'b0;
      pend_q        <= 1'b0;
      ptr_q         <= '0;
      cnt_q         <= '0;
      refr_q        <= '0;
      dly_q         <= '0;
      mode_q        <= LD_COMMON;
      step_q        <= 1'b0;
      k_q           <= 3'd1;
      off_q         <= '0;
      started_q     <= 1'b0;
      end_q         <= 1'b0;
      done_q        <= 1'b0;
    end else begin
      if (start_ok) begin
        st_q          <= ST_PLAY;
        first_q       <= 1'b1;
        shadow_rdy_q  <= 1'b0;
        shadow_last_q <= last_next;
        pend_q        <= 1'b0;
        ptr_q         <= seq_ptr;
        cnt_q         <= seq_cnt;
        refr_q        <= refresh_per;
        dly_q         <= end_delay;
        mode_q        <= load_mode;
        step_q        <= step_mode;
        k_q           <= fetch_k;
        off_q         <= '0;
      end else begin
        if (fetch_rdy) shadow_rdy_q <= 1'b1;
        if (next_step && run_q) pend_q <= 1'b1;
        if (adv_evt) pend_q <= 1'b0;
        if (commit_evt) begin
          first_q      <= 1'b0;
          pend_q       <= 1'b0;
          run_q        <= 1'b1;
          shadow_rdy_q <= 1'b0;
          if (shadow_last_q) begin
            st_q <= ST_TAIL;
          end else begin
            off_q         <= off_q + OW'(k_q);
            shadow_last_q <= last_next;
          end
        end
        if (tail_expire && dly_q != '0) st_q <= ST_DELAY;
        if (finish_evt) begin
          st_q  <= ST_IDLE;
          run_q <= 1'b0;
        end
      end
      started_q <= commit_evt && first_q;
      end_q     <= commit_evt && shadow_last_q;
      done_q    <= finish_evt;
    end
  end

  assign running     = run_q;
  assign seq_started = started_q;
  assign seq_end     = end_q;
  assign seq_done    = done_q;

endmodule

// File: rtl/pwm_seq_player_chk.sv
module pwm_seq_player_chk #(
  parameter int CW   = 14,
  parameter int CMPW = 60
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start,
  input logic [CW-1:0]   seq_cnt,
  input logic            st_idle,
  input logic            next_step,
  input logic            period_end,
  input logic            commit,
  input logic            running,
  input logic            seq_started,
  input logic            seq_done,
  input logic            mem_rd,
  input logic [CMPW-1:0] cmp_val
);

  AST_EMPTY_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (start && seq_cnt == '0 && st_idle) |=> !mem_rd); // R9

  AST_STEP_IDLE_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    (st_idle && next_step && !start) |=> (!running && !mem_rd)); // R7

  AST_RUN_RISE_STARTED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(running) |-> seq_started); // R8

  AST_DONE_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |-> !running); // R11

  AST_COMMIT_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && running) |-> period_end); // R12

  AST_CMP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(commit) |-> $stable(cmp_val)); // R12

endmodule

bind pwm_seq_player pwm_seq_player_chk #(.CW(CW), .CMPW(NCH*(DW-1))) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .seq_cnt    (seq_cnt),
  .st_idle    (st_q == ST_IDLE),
  .next_step  (next_step),
  .period_end (period_end),
  .commit     (commit_evt),
  .running    (running),
  .seq_started(seq_started),
  .seq_done   (seq_done),
  .mem_rd     (mem_rd),
  .cmp_val    (cmp_val)
);

// File: tb/tb_pwm_seq_player.sv
module tb_pwm_seq_player;

  localparam int CLK_PERIOD = 10;
  localparam int AW  = 16;
  localparam int DW  = 16;
  localparam int CW  = 14;
  localparam int RW  = 23;
  localparam int CVW = DW - 1;
  localparam int GAP = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, next_step = 1'b0, period_end = 1'b0;
  logic [AW-1:0] seq_ptr = '0;
  logic [CW-1:0] seq_cnt = '0;
  logic [RW-1:0] refresh_per = '0, end_delay = '0;
  logic [1:0]    load_mode = '0;
  logic          step_mode = 1'b0;
  logic          mem_rd;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_rdata = '0;
  logic [4*CVW-1:0] cmp_val;
  logic [3:0]    cmp_pol;
  logic [CVW-1:0] top_val;
  logic          top_from_mem, running, seq_started, seq_end, seq_done;

  int n_chk = 0, n_fail = 0;
  int n_start = 0, n_end = 0, n_done = 0, n_rd = 0;
  int seed_dummy;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_seq_player #(.AW(AW), .DW(DW), .CW(CW), .RW(RW)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .next_step(next_step),
    .period_end(period_end), .seq_ptr(seq_ptr), .seq_cnt(seq_cnt),
    .refresh_per(refresh_per), .end_delay(end_delay), .load_mode(load_mode),
    .step_mode(step_mode), .mem_rd(mem_rd), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata), .cmp_val(cmp_val), .cmp_pol(cmp_pol),
    .top_val(top_val), .top_from_mem(top_from_mem), .running(running),
    .seq_started(seq_started), .seq_end(seq_end), .seq_done(seq_done)
  );

  function automatic logic [15:0] memfn(input int a);
    logic [31:0] t;
    t = 32'(a) * 32'd40503 + 32'd12345;
    return t[23:8];
  endfunction

  // sample memory: data one cycle after the read strobe
  always @(posedge clk) mem_rdata <= mem_rd ? memfn(int'(mem_addr)) : '0;

  always @(negedge clk) if (rst_n) begin
    if (seq_started) n_start++;
    if (seq_end)     n_end++;
    if (seq_done)    n_done++;
    if (mem_rd)      n_rd++;
  end

  function automatic int per_set(input logic [1:0] m);
    return (m == 2'd0) ? 1 : (m == 2'd1) ? 2 : 4;
  endfunction

  function automatic logic [15:0] exp_sample(input logic [1:0] m, input int ptr,
                                             input int s, input int c);
    int base;
    base = ptr + s * per_set(m);
    case (m)
      2'd0: return memfn(base);
      2'd1: return memfn(base + c / 2);
      2'd2: return memfn(base + c);
      default: return (c == 3) ? 16'h0 : memfn(base + c);
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  task automatic check_set(input logic [1:0] m, input int ptr, input int s);
    string rq;
    logic [15:0] e;
    case (m)
      2'd0: rq = "R1";
      2'd1: rq = "R2";
      2'd2: rq = "R3";
      default: rq = "R4";
    endcase
    for (int c = 0; c < 4; c++) begin
      e = exp_sample(m, ptr, s, c);
      chk(cmp_val[c*CVW +: CVW] == e[14:0], rq, "compare", int'(cmp_val[c*CVW +: CVW]), int'(e[14:0]));
      chk(cmp_pol[c] == e[15], "R5", "polarity", int'(cmp_pol[c]), int'(e[15]));
    end
    e = (m == 2'd3) ? memfn(ptr + s * 4 + 3) : 16'h0;
    chk(top_val == e[14:0], "R4", "top value", int'(top_val), int'(e[14:0]));
    chk(top_from_mem == (m == 2'd3), "R4", "top flag", int'(top_from_mem), int'(m == 2'd3));
  endtask

  task automatic period_tick(input bit with_step);
    if (with_step) begin
      @(negedge clk) next_step = 1'b1;
      @(negedge clk) next_step = 1'b0;
    end
    @(negedge clk) period_end = 1'b1;
    @(negedge clk) period_end = 1'b0;
    repeat (GAP) @(negedge clk);
  endtask

  task automatic do_start(input logic [1:0] m, input bit stp, input int ptr,
                          input int cnt, input int refr, input int dly);
    @(negedge clk);
    load_mode = m; step_mode = stp; seq_ptr = AW'(ptr); seq_cnt = CW'(cnt);
    refresh_per = RW'(refr); end_delay = RW'(dly);
    start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic run_seq(input logic [1:0] m, input bit stp, input int ptr,
                         input int cnt, input int refr, input int dly);
    int k, ns, s0, e0, d0, total, es;
    k = per_set(m);
    ns = (cnt + k - 1) / k;
    s0 = n_start; e0 = n_end; d0 = n_done;
    do_start(m, stp, ptr, cnt, refr, dly);
    for (int w = 0; w < 40 && n_start == s0; w++) @(negedge clk);
    chk(n_start == s0 + 1, "R8", "started pulse from idle", n_start - s0, 1);
    chk(running == 1'b1, "R8", "running after start", int'(running), 1);
    repeat (GAP) @(negedge clk);
    check_set(m, ptr, 0);
    chk((n_end - e0) == int'(ns == 1), "R10", "end pulses at first set", n_end - e0, int'(ns == 1));
    if (!stp) begin
      total = ns * (refr + 1) + dly;
      for (int p = 1; p <= total; p++) begin
        period_tick(1'b0);
        es = p / (refr + 1);
        if (es > ns - 1) es = ns - 1;
        check_set(m, ptr, es);  // R6 pacing
        chk((n_end - e0) == int'(p >= (ns - 1) * (refr + 1)), "R10", "end pulses", n_end - e0,
            int'(p >= (ns - 1) * (refr + 1)));
        chk((n_done - d0) == int'(p == total), "R11", "done pulses", n_done - d0, int'(p == total));
        chk(running == (p < total), "R6", "running", int'(running), int'(p < total));
      end
    end else begin
      for (int s = 1; s <= ns; s++) begin
        period_tick(1'b0);
        check_set(m, ptr, s - 1);  // R7 no step, no advance
        chk(running == 1'b1, "R7", "still running without step", int'(running), 1);
        period_tick(1'b1);
        check_set(m, ptr, (s < ns) ? s : ns - 1);
        chk((n_end - e0) == 1 || s < ns - 1, "R10", "end pulse count", n_end - e0, 1);
        if (s == ns)
          chk((n_done - d0) == int'(dly == 0), "R11", "done after last step", n_done - d0, int'(dly == 0));
      end
      for (int q = 1; q <= dly; q++) begin
        period_tick(1'b0);
        chk((n_done - d0) == int'(q == dly), "R11", "done after delay", n_done - d0, int'(q == dly));
      end
    end
    chk(running == 1'b0, "R11", "idle at end", int'(running), 0);
  endtask

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    summary();
    $finish;
  end

  initial begin
    logic [4*CVW-1:0] snap;
    int r0, s0;
    seed_dummy = $urandom(32'd2024);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cmp_val == '0 && cmp_pol == '0, "R12", "reset compare", int'(cmp_pol), 0);
    chk(running == 1'b0 && mem_rd == 1'b0, "R12", "reset idle", int'(running), 0);
    chk(top_val == '0 && !top_from_mem, "R12", "reset top", int'(top_val), 0);

    // R7: step pulse from idle does nothing
    r0 = n_rd;
    @(negedge clk) next_step = 1'b1;
    @(negedge clk) next_step = 1'b0;
    repeat (8) @(negedge clk);
    chk(running == 1'b0, "R7", "step from idle runs", int'(running), 0);
    chk(n_rd == r0, "R7", "step from idle reads", n_rd - r0, 0);

    // directed runs
    run_seq(2'd0, 1'b0, 100, 3, 1, 2);
    run_seq(2'd1, 1'b0, 300, 5, 0, 1);   // R10 partial last set
    run_seq(2'd2, 1'b0, 500, 8, 2, 0);
    run_seq(2'd3, 1'b0, 700, 8, 0, 3);
    run_seq(2'd2, 1'b1, 900, 12, 0, 2);
    run_seq(2'd0, 1'b1, 40, 2, 1, 0);

    // R9: empty start ignored
    snap = cmp_val; r0 = n_rd; s0 = n_start;
    do_start(2'd2, 1'b0, 1234, 0, 0, 0);
    repeat (12) @(negedge clk);
    chk(n_rd == r0, "R9", "reads on empty start", n_rd - r0, 0);
    chk(n_start == s0, "R9", "started on empty start", n_start - s0, 0);
    chk(running == 1'b0 && cmp_val == snap, "R9", "outputs on empty start", int'(running), 0);

    // R8/R12: restart while running waits for a period end
    do_start(2'd2, 1'b0, 2000, 8, 0, 0);
    for (int w = 0; w < 40 && !running; w++) @(negedge clk);
    repeat (GAP) @(negedge clk);
    period_tick(1'b0);
    check_set(2'd2, 2000, 1);
    s0 = n_start;
    do_start(2'd2, 1'b0, 3000, 8, 0, 0);
    repeat (12) @(negedge clk);
    check_set(2'd2, 2000, 1);
    chk(n_start == s0, "R12", "no commit before period end", n_start - s0, 0);
    period_tick(1'b0);
    check_set(2'd2, 3000, 0);
    chk(n_start == s0 + 1, "R8", "started pulse on restart", n_start - s0, 1);
    period_tick(1'b0);
    check_set(2'd2, 3000, 1);
    period_tick(1'b0);
    chk(running == 1'b0, "R11", "restart run finished", int'(running), 0);

    // random runs
    for (int i = 0; i < 10; i++) begin
      logic [1:0] m;
      bit stp;
      m   = 2'($urandom_range(0, 3));
      stp = 1'($urandom_range(0, 1));
      run_seq(m, stp, int'($urandom_range(0, 4000)), int'($urandom_range(1, 9)),
              int'($urandom_range(0, 2)), int'($urandom_range(0, 3)));
    end

    summary();
    $finish;
  end

endmodule